// File: doc/BRIEF.md
# Horizontal Window Scaler with Colour Expansion

This block builds one scaled output line of a display window from a line of source pixels that is already stored on chip. Software supplies the source and output widths and heights, a pixel format select and an enable. Each pulse on the line-start strobe walks a fixed-point position accumulator across the source line. For every output pixel the block reads the nearest source sample at the integer part of that position. It converts the sample to 24-bit RGB and offers it on a valid/ready output stream.

The step size is a fixed-point increment with 12 fractional bits. It is the source size times 4096 divided by the output size less one, and the divisor is never allowed below one. The block derives both a horizontal and a vertical step and exports them together on one word, horizontal in the low half. Only the horizontal step drives the scaler itself. The block also exports the length of a source line in bytes.

The source read port is combinational: `rd_addr` selects a pixel and `rd_data` must return that pixel in the same cycle. The output stream follows valid/ready rules. A pixel transfers on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the pixel is held unchanged and the accumulator does not move. The block never withdraws a pixel it has offered. Configuration must be stable from at least two cycles before a line-start strobe until the line has finished.

Top module: `wsc_scaler`

## Requirements
- R1: `step_word` holds the horizontal increment `cfg_src_w*4096 / max(cfg_out_w-1,1)` in its low 23 bits and the vertical increment `cfg_src_h*4096 / max(cfg_out_h-1,1)` in its high 23 bits, one clock after the configuration is applied.
- R2: `line_bytes` equals `cfg_src_w*2` when `cfg_fmt`=0 and `cfg_src_w*4` when `cfg_fmt`=1.
- R3: A line-start strobe with `cfg_en` high clears the accumulator, so the first output pixel of every line comes from source index 0.
- R4: Output pixel k (counting from 0) comes from source index `(k*step_h) >> 12`, limited to at most `cfg_src_w-1`.
- R5: Each enabled line transfers exactly `cfg_out_w` pixels, then `out_valid` stays low until the next strobe; `cfg_out_w`=0 gives no pixels.
- R6: With `cfg_fmt`=0, the 16-bit pixel sits in `rd_data[15:0]` with blue in [15:11], green in [10:5] and red in [4:0]. Each channel widens to 8 bits by copying its top bits into the vacated low bits. The output is red in `out_rgb[23:16]`, green in [15:8] and blue in [7:0].
- R7: With `cfg_fmt`=1, red is `rd_data[7:0]`, green [15:8], blue [23:16]; the alpha byte [31:24] is dropped; the output layout is as in R6.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_rgb` is unchanged, and no pixel is skipped or repeated.
- R9: A line-start strobe while `cfg_en` is low and no line is in progress produces no pixels.
- R10: During and right after reset `out_valid` is low and no line is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Window enable; strobes are ignored while low |
| cfg_fmt | input | 1 | Pixel format: 0 = 16-bit, 1 = 32-bit |
| cfg_src_w | input | 11 | Source line width in pixels |
| cfg_src_h | input | 11 | Source height in lines |
| cfg_out_w | input | 11 | Output line width in pixels |
| cfg_out_h | input | 11 | Output height in lines |
| line_start | input | 1 | One-cycle strobe that begins a line |
| rd_addr | output | 11 | Source pixel index to read |
| rd_data | input | 32 | Source pixel at `rd_addr`, same cycle |
| out_valid | output | 1 | Output pixel is offered |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_rgb | output | 24 | Output pixel, R in [23:16], G in [15:8], B in [7:0] |
| step_word | output | 46 | Vertical step [45:23], horizontal step [22:0] |
| line_bytes | output | 13 | Source line length in bytes |

## Verification
The assertions check four things on every cycle. A held pixel stays valid and stable under back-pressure. The read index never reaches past the source width while a line runs. A started line always reads index 0 first. A disabled strobe never starts a line. They also check that every 16-bit output carries replicated low bits in all three channels. Only the bench scenarios can show the arithmetic itself: the exact increment and byte-length values, the nearest-sample sequence for upscaling and downscaling, the clamp at the last pixel, and the exact pixel count per line, including zero-width lines and disabled strobes.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic {
    PIX_B5G6R5 = 1'b0,
    PIX_RGBA8  = 1'b1
  } pix_fmt_e;

  localparam int FRAC_BITS = 12;
endpackage

// File: rtl/wsc_step.sv
module wsc_step #(
  parameter int DIM_W = 11,
  parameter int FRAC  = 12,
  localparam int INC_W = DIM_W + FRAC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0][DIM_W-1:0]  src_sz,
  input  logic [1:0][DIM_W-1:0]  dst_sz,
  output logic [1:0][INC_W-1:0]  step
);
  for (genvar g = 0; g < 2; g++) begin : g_axis
    logic [DIM_W-1:0] divisor;
    logic [INC_W-1:0] numer;
    logic [INC_W-1:0] quot;

    always_comb begin
      divisor = (dst_sz[g] <= DIM_W'(1)) ? DIM_W'(1) : dst_sz[g] - DIM_W'(1);
      numer   = {src_sz[g], {FRAC{1'b0}}};
      quot    = numer / INC_W'(divisor);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step[g] <= '0;
      else        step[g] <= quot;
    end
  end
endmodule

// File: rtl/wsc_expand.sv
module wsc_expand
  import wsc_pkg::*;
(
  input  logic        fmt,
  input  logic [31:0] pix,
  output logic [23:0] rgb
);
  logic [4:0] b5, r5;
  logic [5:0] g6;

  always_comb begin
    b5 = pix[15:11];
    g6 = pix[10:5];
    r5 = pix[4:0];
    if (fmt == PIX_RGBA8)
      rgb = {pix[7:0], pix[15:8], pix[23:16]};
    else
      rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
  end
endmodule

// File: rtl/wsc_walker.sv
module wsc_walker #(
  parameter int DIM_W = 11,
  parameter int FRAC  = 12,
  localparam int INC_W = DIM_W + FRAC,
  localparam int ACC_W = INC_W + 1,
  localparam int IDX_W = ACC_W - FRAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] out_w,
  input  logic [INC_W-1:0] inc,
  input  logic             advance,
  output logic             busy,
  output logic             fire,
  output logic [DIM_W-1:0] idx
);
  logic [ACC_W-1:0] acc;
  logic [DIM_W-1:0] remaining;
  logic [IDX_W-1:0] idx_raw;

  assign busy = (remaining != '0);
  assign fire = busy && advance;

  always_comb begin
    idx_raw = acc[ACC_W-1:FRAC];
    if (idx_raw >= IDX_W'(src_w))
      idx = (src_w == '0) ? '0 : src_w - DIM_W'(1);
    else
      idx = idx_raw[DIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      remaining <= '0;
    end else if (start && en) begin
      acc       <= '0;
      remaining <= out_w;
    end else if (fire) begin
      acc       <= acc + ACC_W'(inc);
      remaining <= remaining - DIM_W'(1);
    end
  end

  AST_FIRST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en) |=> (idx == '0)); // R3

  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_w != '0) |-> (idx < src_w)); // R4

  AST_DISABLED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !en && !busy) |=> !busy); // R9
endmodule

// File: rtl/wsc_scaler.sv
module wsc_scaler
  import wsc_pkg::*;
#(
  parameter int DIM_W = 11,
  localparam int FRAC  = FRAC_BITS,
  localparam int INC_W = DIM_W + FRAC,
  localparam int LB_W  = DIM_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_fmt,
  input  logic [DIM_W-1:0]   cfg_src_w,
  input  logic [DIM_W-1:0]   cfg_src_h,
  input  logic [DIM_W-1:0]   cfg_out_w,
  input  logic [DIM_W-1:0]   cfg_out_h,
  input  logic               line_start,
  output logic [DIM_W-1:0]   rd_addr,
  input  logic [31:0]        rd_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [23:0]        out_rgb,
  output logic [2*INC_W-1:0] step_word,
  output logic [LB_W-1:0]    line_bytes
);
  logic [1:0][INC_W-1:0] step;
  logic                  busy, fire, advance, out_is16;
  logic [23:0]           pix_rgb;

  wsc_step #(.DIM_W(DIM_W), .FRAC(FRAC)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_sz ({cfg_src_h, cfg_src_w}),
    .dst_sz ({cfg_out_h, cfg_out_w}),
    .step   (step)
  );

  assign step_word  = {step[1], step[0]};
  assign line_bytes = (cfg_fmt == PIX_RGBA8) ? {cfg_src_w, 2'b00}
                                             : {1'b0, cfg_src_w, 1'b0};
  assign advance    = !out_valid || out_ready;

  wsc_walker #(.DIM_W(DIM_W), .FRAC(FRAC)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (line_start),
    .en      (cfg_en),
    .src_w   (cfg_src_w),
    .out_w   (cfg_out_w),
    .inc     (step[0]),
    .advance (advance),
    .busy    (busy),
    .fire    (fire),
    .idx     (rd_addr)
  );

  wsc_expand u_exp (
    .fmt (cfg_fmt),
    .pix (rd_data),
    .rgb (pix_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_is16  <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_rgb   <= pix_rgb;
      out_is16  <= (cfg_fmt == PIX_B5G6R5);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb))); // R8

  AST_EXPAND_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is16) |-> (out_rgb[18:16] == out_rgb[23:21] &&
                                 out_rgb[9:8]   == out_rgb[15:14] &&
                                 out_rgb[2:0]   == out_rgb[7:5])); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R10
endmodule

// File: tb/wsc_scaler_test.sv
module wsc_scaler_test;
  localparam int DIM_W = 11;
  localparam int INC_W = DIM_W + 12;

  logic               clk = 1'b0;
  logic               rst_n, cfg_en, cfg_fmt, line_start, out_valid, out_ready;
  logic [DIM_W-1:0]   cfg_src_w, cfg_src_h, cfg_out_w, cfg_out_h, rd_addr;
  logic [31:0]        rd_data;
  logic [23:0]        out_rgb;
  logic [2*INC_W-1:0] step_word;
  logic [DIM_W+1:0]   line_bytes;

  logic [31:0] mem [16];
  logic [23:0] exp_q [$];
  int checks = 0, errors = 0, xfers = 0, cyc = 0;
  bit bp_mode = 0;

  always #2 clk = ~clk;

  assign rd_data = mem[rd_addr[3:0]];

  wsc_scaler #(.DIM_W(DIM_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fmt(cfg_fmt),
    .cfg_src_w(cfg_src_w), .cfg_src_h(cfg_src_h), .cfg_out_w(cfg_out_w),
    .cfg_out_h(cfg_out_h), .line_start(line_start), .rd_addr(rd_addr),
    .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgb(out_rgb), .step_word(step_word), .line_bytes(line_bytes)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_pix(input logic [31:0] w, input bit f);
    logic [4:0] r, b;
    logic [5:0] g;
    if (f) return {w[7:0], w[15:8], w[23:16]};
    b = w[15:11]; g = w[10:5]; r = w[4:0];
    return {r, r[4:2], g, g[5:4], b, b[4:2]};
  endfunction

  // ready generator: toggles when back-pressure mode is on
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = bp_mode ? ((cyc % 3) != 1) : 1'b1;
    end
  end

  // monitor: pops the scoreboard on each transfer
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid && out_ready) begin
      xfers++;
      if (exp_q.size() == 0)
        chk(0, "R5 extra pixel", 64'(out_rgb), 64'h0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(out_rgb == e, "R3 R4 R6 R7 R8 pixel", 64'(out_rgb), 64'(e));
      end
    end
  end

  task automatic run_line(input int src, input int outw, input bit f,
                          input bit en, input bit bp);
    int eh, ev, x0;
    logic [2*INC_W-1:0] ew;
    @(posedge clk); #1;
    cfg_en = en; cfg_fmt = f; cfg_src_w = DIM_W'(src); cfg_out_w = DIM_W'(outw);
    cfg_src_h = DIM_W'(src + 1); cfg_out_h = DIM_W'(outw + 2);
    bp_mode = bp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    eh = (src * 4096) / ((outw <= 1) ? 1 : outw - 1);
    ev = ((src + 1) * 4096) / (outw + 1);
    ew = {INC_W'(ev), INC_W'(eh)};
    chk(step_word == ew, "R1 step word", 64'(step_word), 64'(ew));
    chk(line_bytes == (DIM_W+2)'(src * (f ? 4 : 2)), "R2 line bytes",
        64'(line_bytes), 64'(src * (f ? 4 : 2)));
    if (en)
      for (int k = 0; k < outw; k++) begin
        int idx;
        idx = (k * eh) >> 12;
        if (idx >= src) idx = src - 1;
        exp_q.push_back(model_pix(mem[idx], f));
      end
    x0 = xfers;
    @(posedge clk); #1 line_start = 1'b1;
    @(posedge clk); #1 line_start = 1'b0;
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(posedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(xfers - x0 == (en ? outw : 0), "R5 R9 pixel count",
        64'(xfers - x0), 64'(en ? outw : 0));
    chk(out_valid == 1'b0, "R5 idle after line", 64'(out_valid), 64'h0);
    bp_mode = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 0; cfg_fmt = 0; line_start = 0;
    cfg_src_w = '0; cfg_src_h = '0; cfg_out_w = '0; cfg_out_h = '0;
    for (int i = 0; i < 16; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", 64'(out_valid), 64'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 after reset", 64'(out_valid), 64'h0);

    run_line(8, 5, 0, 1, 0);   // downscale, 16-bit
    run_line(4, 10, 1, 1, 1);  // upscale, 32-bit, back-pressure
    run_line(5, 1, 0, 1, 0);   // divisor floor of one
    run_line(3, 3, 1, 1, 1);   // clamp on last pixel, R4
    run_line(6, 0, 0, 1, 0);   // zero-width line, R5
    run_line(6, 4, 0, 0, 0);   // disabled strobe, R9
    run_line(12, 7, 1, 1, 1);  // wider source with stalls

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule